// File: doc/BRIEF.md
# Computational Memory Word Logic Unit

This block is a cycle-level digital model of a small resistive memory with a logic-capable sense stage. There are two twin banks of words. A single command, qualified by `start`, names a 4-bit control code, a mode bit, up to three source rows in one bank, a destination row, write data, a shift code and an optional single-bit target. In the clock edge that accepts the command, the sense stage combines the active rows bitwise as OR, AND, XOR or 3-input majority. It can invert the result and shift it by one position. The result is then stored back into the same bank, stored into the twin bank, or driven onto the read port.

The control code is decoded as follows:
- Bit 3 selects an external write.
- Bits 2:1 pick the sense function.
- Bit 0 requests inversion.

Because the row count travels with the command, one code serves both AND (two rows) and majority (three rows). Commands that make no sense are refused: they change no state and raise a one-cycle error pulse instead of `done`. Chained majority and XOR steps with a one-position shift and single-bit stores are enough to build ripple arithmetic inside the memory.

Top module: `cmem_logic_unit`

## Requirements
- R1: After reset, `rdData`, `done` and `err` are 0 and every word of both banks reads as 0.
- R2: A command with `code[3]`=1 and `mode`=0 stores `wrData` into row `dstAddr` of bank `arraySel`. Bits `code[2:0]`, the row count and the shift code are ignored. `done` is high for exactly the one cycle after the accepting edge.
- R3: A command with `code[3:1]`=000, `mode`=0 and `rowCount`=1 loads `rdData` with row `rowA` of bank `arraySel`, after inversion and shift, and stores nothing. `rdData` changes on no other command.
- R4: When `code[3]`=0, bits `code[2:1]` select the sense function: 00 is OR of all active rows (1 to 3), 01 with `rowCount`=2 is AND of `rowA` and `rowB`, and 10 with `rowCount`=2 is XOR of `rowA` and `rowB`. With `mode`=0 and `rowCount`≥2, the result is stored at `dstAddr` of bank `arraySel`.
- R5: `code[2:1]`=01 with `rowCount`=3 stores the bitwise majority of `rowA`, `rowB` and `rowC`.
- R6: With `mode`=1, the sense result goes to row `dstAddr` of the twin bank (`arraySel` inverted). With `code`=0000 and `rowCount`=1, this copies `rowA` across.
- R7: `code[0]`=1 inverts the sense result, giving NOR, NAND, XNOR, inverted majority and inverted read or copy.
- R8: `shiftCode` 001 shifts the (possibly inverted) result one place toward the MSB, 010 shifts it one place toward the LSB, and 000 leaves it alone. The vacated bit is 0.
- R9: When `bitSelEn`=1, a store updates only bit `bitSelIdx` of the destination word, and all other bits keep their value. Bit selection has no effect on reads.
- R10: The following commands are illegal:
  - `code[3]`=1 with `mode`=1;
  - `code[3]`=0 with `rowCount`=0;
  - `code[2:1]`=11;
  - AND with `rowCount`=1;
  - XOR with `rowCount`≠2;
  - a non-write command whose `shiftCode` is not 000, 001 or 010.

  An illegal command changes no word and leaves `rdData` unchanged. It raises `err` for one cycle, and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command valid for this edge |
| code | input | 4 | Control code: write, function, invert |
| mode | input | 1 | 0: same bank or read port, 1: twin bank |
| rowCount | input | 2 | Number of active source rows (0 to 3) |
| rowA | input | ADDR_W | First source row |
| rowB | input | ADDR_W | Second source row |
| rowC | input | ADDR_W | Third source row |
| arraySel | input | 1 | Bank holding the source rows |
| dstAddr | input | ADDR_W | Destination row |
| wrData | input | WIDTH | External write data |
| shiftCode | input | 3 | Shift select |
| bitSelEn | input | 1 | Single-bitline store enable |
| bitSelIdx | input | BIT_W | Target bit for single-bitline store |
| rdData | output | WIDTH | Read port |
| done | output | 1 | Command accepted (one cycle) |
| err | output | 1 | Command refused (one cycle) |

## Verification
The bench goes after the decode corners:
- Majority versus AND on the same code, separated only by the row count. A design keyed on the code alone would store AND where a majority was asked for.
- Twin-bank writes, which a design could let through and corrupt the twin bank.
- XOR with three rows, and the undefined shift codes.

It also drives shifts at the word edges, where a wrong implementation would wrap the MSB or LSB around instead of dropping it. It checks single-bit stores, which a careless mask would spread to the whole word. Finally, it confirms that bit selection leaves reads untouched.

// File: rtl/cmem_pkg.sv
package cmem_pkg;

  typedef enum logic [1:0] {
    SENSE_OR  = 2'd0,
    SENSE_AND = 2'd1,
    SENSE_MAJ = 2'd2,
    SENSE_XOR = 2'd3
  } senseOp_e;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_LEFT  = 2'd1,
    SHIFT_RIGHT = 2'd2
  } shiftDir_e;

  localparam logic [2:0] SHCODE_NONE  = 3'b000;
  localparam logic [2:0] SHCODE_LEFT  = 3'b001;
  localparam logic [2:0] SHCODE_RIGHT = 3'b010;

  localparam logic [1:0] FN_OR  = 2'b00;
  localparam logic [1:0] FN_AND = 2'b01;
  localparam logic [1:0] FN_XOR = 2'b10;

  // Strobes from control to datapath, valid in the accepting cycle.
  typedef struct packed {
    logic      storeEn;    // write a word this edge
    logic      storeTwin;  // destination is the twin bank
    logic      storeExt;   // store external data instead of sense result
    logic      readEn;     // load the read port
    senseOp_e  op;
    logic [1:0] rowsActive;
    logic      invert;
    shiftDir_e shift;
  } ctrlStrobes_t;

endpackage

// File: rtl/cmem_ctrl.sv
module cmem_ctrl
  import cmem_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [3:0]   code,
  input  logic         mode,
  input  logic [1:0]   rowCount,
  input  logic [2:0]   shiftCode,
  output ctrlStrobes_t strobes,
  output logic         done,
  output logic         err
);

  logic legal;
  logic shiftOk;
  logic isRead;
  ctrlStrobes_t decoded;

  always_comb begin
    shiftOk = (shiftCode == SHCODE_NONE) || (shiftCode == SHCODE_LEFT) ||
              (shiftCode == SHCODE_RIGHT);
    isRead  = 1'b0;
    legal   = 1'b0;
    decoded = '0;
    decoded.op         = SENSE_OR;
    decoded.rowsActive = rowCount;
    decoded.invert     = code[0];
    decoded.storeTwin  = mode;
    unique case (shiftCode)
      SHCODE_LEFT:  decoded.shift = SHIFT_LEFT;
      SHCODE_RIGHT: decoded.shift = SHIFT_RIGHT;
      default:      decoded.shift = SHIFT_NONE;
    endcase

    if (code[3]) begin
      legal            = !mode;
      decoded.storeExt = 1'b1;
    end else if (rowCount != 2'd0) begin
      unique case (code[2:1])
        FN_OR: begin
          decoded.op = SENSE_OR;
          legal      = shiftOk;
          isRead     = (rowCount == 2'd1) && !mode;
        end
        FN_AND: begin
          decoded.op = (rowCount == 2'd3) ? SENSE_MAJ : SENSE_AND;
          legal      = shiftOk && (rowCount != 2'd1);
        end
        FN_XOR: begin
          decoded.op = SENSE_XOR;
          legal      = shiftOk && (rowCount == 2'd2);
        end
        default: legal = 1'b0;
      endcase
    end

    decoded.readEn  = start && legal && isRead;
    decoded.storeEn = start && legal && !isRead;
  end

  assign strobes = decoded;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= start && legal;
      err  <= start && !legal;
    end
  end

endmodule

// File: rtl/cmem_sense.sv
module cmem_sense
  import cmem_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] wordA,
  input  logic [WIDTH-1:0] wordB,
  input  logic [WIDTH-1:0] wordC,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] senseOut
);

  logic             useB;
  logic             useC;
  logic [WIDTH-1:0] raw;
  logic [WIDTH-1:0] polar;

  assign useB = (strobes.rowsActive >= 2'd2);
  assign useC = (strobes.rowsActive == 2'd3);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign raw[i] =
      (strobes.op == SENSE_OR)  ? (wordA[i] | (wordB[i] & useB) | (wordC[i] & useC)) :
      (strobes.op == SENSE_AND) ? (wordA[i] & wordB[i]) :
      (strobes.op == SENSE_MAJ) ? ((wordA[i] & wordB[i]) | (wordA[i] & wordC[i]) |
                                   (wordB[i] & wordC[i])) :
                                  (wordA[i] ^ wordB[i]);
  end

  assign polar = strobes.invert ? ~raw : raw;

  always_comb begin
    unique case (strobes.shift)
      SHIFT_LEFT:  senseOut = {polar[WIDTH-2:0], 1'b0};
      SHIFT_RIGHT: senseOut = {1'b0, polar[WIDTH-1:1]};
      default:     senseOut = polar;
    endcase
  end

endmodule

// File: rtl/cmem_datapath.sv
module cmem_datapath
  import cmem_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WIDTH),
  localparam int BANKS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] rowA,
  input  logic [ADDR_W-1:0] rowB,
  input  logic [ADDR_W-1:0] rowC,
  input  logic              arraySel,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              bitSelEn,
  input  logic [BIT_W-1:0]  bitSelIdx,
  output logic [WIDTH-1:0]  rdData
);

  logic [WIDTH-1:0] mem [BANKS][DEPTH];
  logic [WIDTH-1:0] wordA;
  logic [WIDTH-1:0] wordB;
  logic [WIDTH-1:0] wordC;
  logic [WIDTH-1:0] senseOut;
  logic [WIDTH-1:0] storeVal;
  logic [WIDTH-1:0] laneMask;
  logic             tgtBank;

  assign wordA = mem[arraySel][rowA];
  assign wordB = mem[arraySel][rowB];
  assign wordC = mem[arraySel][rowC];

  cmem_sense #(.WIDTH(WIDTH)) u_sense (
    .wordA    (wordA),
    .wordB    (wordB),
    .wordC    (wordC),
    .strobes  (strobes),
    .senseOut (senseOut)
  );

  assign storeVal = strobes.storeExt ? wrData : senseOut;
  assign tgtBank  = arraySel ^ strobes.storeTwin;
  assign laneMask = bitSelEn ? (WIDTH'(1) << bitSelIdx) : {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < BANKS; b++) begin
        for (int r = 0; r < DEPTH; r++) begin
          mem[b][r] <= '0;
        end
      end
      rdData <= '0;
    end else begin
      if (strobes.storeEn) begin
        mem[tgtBank][dstAddr] <= (mem[tgtBank][dstAddr] & ~laneMask) |
                                 (storeVal & laneMask);
      end
      if (strobes.readEn) begin
        rdData <= senseOut;
      end
    end
  end

endmodule

// File: rtl/cmem_logic_unit.sv
module cmem_logic_unit
  import cmem_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        code,
  input  logic              mode,
  input  logic [1:0]        rowCount,
  input  logic [ADDR_W-1:0] rowA,
  input  logic [ADDR_W-1:0] rowB,
  input  logic [ADDR_W-1:0] rowC,
  input  logic              arraySel,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [2:0]        shiftCode,
  input  logic              bitSelEn,
  input  logic [BIT_W-1:0]  bitSelIdx,
  output logic [WIDTH-1:0]  rdData,
  output logic              done,
  output logic              err
);

  ctrlStrobes_t strobes;

  cmem_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .code      (code),
    .mode      (mode),
    .rowCount  (rowCount),
    .shiftCode (shiftCode),
    .strobes   (strobes),
    .done      (done),
    .err       (err)
  );

  cmem_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rowA      (rowA),
    .rowB      (rowB),
    .rowC      (rowC),
    .arraySel  (arraySel),
    .dstAddr   (dstAddr),
    .wrData    (wrData),
    .bitSelEn  (bitSelEn),
    .bitSelIdx (bitSelIdx),
    .rdData    (rdData)
  );

endmodule

// File: rtl/cmem_checker.sv
module cmem_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [3:0]       code,
  input logic             mode,
  input logic [WIDTH-1:0] rdData,
  input logic             done,
  input logic             err
);

  // R10: accepted and refused never coincide
  a_r10_done_err_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R2: done only follows an edge that saw start
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  // R10: err only follows an edge that saw start
  a_r10_err_after_start: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $past(start));

  // R10: an external write aimed at the twin bank is refused
  a_r10_twin_write_refused: assert property (@(posedge clk) disable iff (!rstN)
    (start && mode && code[3]) |=> (err && !done));

  // R3: read port holds when no command was accepted
  a_r3_read_port_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(start) |-> $stable(rdData));

  // R10: a refused command leaves the read port alone
  a_r10_err_keeps_read: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(rdData));

endmodule

bind cmem_logic_unit cmem_checker #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .code   (code),
  .mode   (mode),
  .rdData (rdData),
  .done   (done),
  .err    (err)
);

// File: tb/sim_cmem_logic_unit.sv
module sim_cmem_logic_unit;

  localparam int W  = 8;
  localparam int D  = 8;
  localparam int AW = $clog2(D);
  localparam int BW = $clog2(W);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    code = '0;
  logic          mode = 1'b0;
  logic [1:0]    rowCount = '0;
  logic [AW-1:0] rowA = '0, rowB = '0, rowC = '0, dstAddr = '0;
  logic          arraySel = 1'b0;
  logic [W-1:0]  wrData = '0;
  logic [2:0]    shiftCode = '0;
  logic          bitSelEn = 1'b0;
  logic [BW-1:0] bitSelIdx = '0;
  logic [W-1:0]  rdData;
  logic          done, err;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [W-1:0] model [2][D];
  logic [W-1:0] expRd = '0;

  always #2 clk = ~clk;

  cmem_logic_unit #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .code(code), .mode(mode),
    .rowCount(rowCount), .rowA(rowA), .rowB(rowB), .rowC(rowC),
    .arraySel(arraySel), .dstAddr(dstAddr), .wrData(wrData),
    .shiftCode(shiftCode), .bitSelEn(bitSelEn), .bitSelIdx(bitSelIdx),
    .rdData(rdData), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit modelLegal(logic [3:0] c, logic m, logic [1:0] n, logic [2:0] s);
    if (c[3]) return !m;
    if (s > 3'd2 || n == 2'd0) return 0;
    case (c[2:1])
      2'b00:   return 1;
      2'b01:   return n >= 2'd2;
      2'b10:   return n == 2'd2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] modelSense(logic [W-1:0] a, logic [W-1:0] b,
      logic [W-1:0] c, logic [1:0] n, logic [3:0] cd, logic [2:0] s);
    logic [W-1:0] r;
    case (cd[2:1])
      2'b00:   r = a | ((n >= 2) ? b : '0) | ((n == 3) ? c : '0);
      2'b01:   r = (n == 3) ? ((a & b) | (a & c) | (b & c)) : (a & b);
      default: r = a ^ b;
    endcase
    if (cd[0]) r = ~r;
    if (s == 3'b001) r = r << 1;
    else if (s == 3'b010) r = r >> 1;
    return r;
  endfunction

  task automatic runOp(input logic [3:0] c, input logic m, input logic [1:0] n,
      input logic [AW-1:0] ra, input logic [AW-1:0] rb, input logic [AW-1:0] rc,
      input logic sel, input logic [AW-1:0] dst, input logic [W-1:0] wd,
      input logic [2:0] s, input logic be, input logic [BW-1:0] bi, input string tag);
    bit legal;
    bit isRead;
    logic [W-1:0] val, mask;
    logic tgt;
    legal  = modelLegal(c, m, n, s);
    isRead = legal && !c[3] && c[2:1] == 2'b00 && !m && n == 2'd1;
    val    = c[3] ? wd : modelSense(model[sel][ra], model[sel][rb], model[sel][rc], n, c, s);
    @(negedge clk);
    code = c; mode = m; rowCount = n; rowA = ra; rowB = rb; rowC = rc;
    arraySel = sel; dstAddr = dst; wrData = wd; shiftCode = s;
    bitSelEn = be; bitSelIdx = bi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == legal, {tag, " done"}, W'(done), W'(legal));
    check(err == !legal, {tag, " err"}, W'(err), W'(!legal));
    if (isRead) expRd = val;
    check(rdData == expRd, {tag, " rdData"}, rdData, expRd);
    if (legal && !isRead) begin
      tgt  = sel ^ m;
      mask = be ? (W'(1) << bi) : {W{1'b1}};
      model[tgt][dst] = (model[tgt][dst] & ~mask) | (val & mask);
    end
  endtask

  task automatic wr(input logic sel, input logic [AW-1:0] dst, input logic [W-1:0] d);
    runOp(4'b1000, 0, 2'd1, 0, 0, 0, sel, dst, d, 3'b000, 0, 0, "R2");
  endtask

  task automatic rd(input logic sel, input logic [AW-1:0] r, input string tag);
    runOp(4'b0000, 0, 2'd1, r, 0, 0, sel, 0, 0, 3'b000, 0, 0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finish();
  end

  initial begin
    int seed;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < D; r++) model[b][r] = '0;
    seed = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(rdData == '0, "R1 rdData", rdData, '0);
    check(done == 1'b0, "R1 done", W'(done), '0);
    check(err == 1'b0, "R1 err", W'(err), '0);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < D; r++) rd(b[0], AW'(r), "R1");

    // R2 write ignores low code bits, R3 read
    wr(0, 1, 8'b0000_0011);
    runOp(4'b1111, 0, 2'd0, 0, 0, 0, 0, 2, 8'b0000_0101, 3'b111, 0, 0, "R2");
    wr(0, 3, 8'b1000_0001);
    rd(0, 1, "R3"); rd(0, 2, "R3");
    // R4 OR/AND/XOR stored in same bank, OR over three rows
    runOp(4'b0000, 0, 2'd2, 1, 2, 0, 0, 4, 0, 3'b000, 0, 0, "R4");
    rd(0, 4, "R4");
    runOp(4'b0010, 0, 2'd2, 1, 2, 0, 0, 5, 0, 3'b000, 0, 0, "R4");
    rd(0, 5, "R4");
    runOp(4'b0100, 0, 2'd2, 1, 2, 0, 0, 6, 0, 3'b000, 0, 0, "R4");
    rd(0, 6, "R4");
    runOp(4'b0000, 0, 2'd3, 1, 2, 3, 0, 7, 0, 3'b000, 0, 0, "R4");
    rd(0, 7, "R4");
    // R5 majority vs AND on same code
    runOp(4'b0010, 0, 2'd3, 1, 2, 3, 0, 0, 0, 3'b000, 0, 0, "R5");
    rd(0, 0, "R5");
    // R6 copy to twin, logic to twin
    runOp(4'b0000, 1, 2'd1, 3, 0, 0, 0, 2, 0, 3'b000, 0, 0, "R6");
    rd(1, 2, "R6");
    runOp(4'b0100, 1, 2'd2, 1, 3, 0, 0, 5, 0, 3'b000, 0, 0, "R6");
    rd(1, 5, "R6"); rd(0, 5, "R6");
    // R7 inversion: NOR, NAND, inverted read
    runOp(4'b0001, 0, 2'd2, 1, 3, 0, 0, 6, 0, 3'b000, 0, 0, "R7");
    rd(0, 6, "R7");
    runOp(4'b0011, 0, 2'd2, 1, 3, 0, 0, 6, 0, 3'b000, 0, 0, "R7");
    rd(0, 6, "R7");
    runOp(4'b0001, 0, 2'd1, 3, 0, 0, 0, 0, 0, 3'b000, 0, 0, "R7");
    // R8 shifts drop edge bits
    runOp(4'b0000, 0, 2'd1, 3, 0, 0, 0, 0, 0, 3'b001, 0, 0, "R8");
    runOp(4'b0000, 0, 2'd1, 3, 0, 0, 0, 0, 0, 3'b010, 0, 0, "R8");
    runOp(4'b0010, 1, 2'd3, 1, 2, 3, 0, 4, 0, 3'b001, 0, 0, "R8");
    rd(1, 4, "R8");
    // R9 single bitline stores, ignored on read
    wr(1, 6, 8'hA5);
    runOp(4'b1000, 0, 2'd1, 0, 0, 0, 1, 6, 8'h00, 3'b000, 1, 3'd5, "R9");
    runOp(4'b0000, 0, 2'd1, 6, 0, 0, 1, 0, 0, 3'b000, 1, 3'd1, "R9");
    runOp(4'b0000, 1, 2'd1, 3, 0, 0, 0, 6, 0, 3'b000, 1, 3'd7, "R9");
    rd(1, 6, "R9");
    // R10 illegal commands change nothing
    runOp(4'b1000, 1, 2'd1, 0, 0, 0, 0, 1, 8'hFF, 3'b000, 0, 0, "R10");
    runOp(4'b0000, 0, 2'd0, 1, 2, 3, 0, 1, 0, 3'b000, 0, 0, "R10");
    runOp(4'b0110, 0, 2'd2, 1, 2, 3, 0, 1, 0, 3'b000, 0, 0, "R10");
    runOp(4'b0010, 0, 2'd1, 3, 2, 3, 0, 1, 0, 3'b000, 0, 0, "R10");
    runOp(4'b0100, 0, 2'd3, 1, 2, 3, 0, 1, 0, 3'b000, 0, 0, "R10");
    runOp(4'b0000, 0, 2'd2, 1, 2, 3, 0, 1, 0, 3'b011, 0, 0, "R10");
    runOp(4'b0000, 0, 2'd1, 3, 0, 0, 0, 0, 0, 3'b110, 0, 0, "R10");
    rd(0, 1, "R10"); rd(1, 1, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] s;
      s = ($urandom % 8 < 6) ? 3'($urandom % 3) : 3'($urandom);
      runOp(4'($urandom), 1'($urandom), 2'($urandom), AW'($urandom), AW'($urandom),
            AW'($urandom), 1'($urandom), AW'($urandom), W'($urandom), s,
            ($urandom % 4 == 0), BW'($urandom), "R4 random");
    end
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < D; r++) rd(b[0], AW'(r), "R9 sweep");
    finish();
  end

endmodule